// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block sits on the host side of an asynchronous parallel EEPROM. It produces the address, data, chip-select, write-strobe and read-strobe lines for byte and page writes. Writes come in over a valid/ready request port that carries an address, a data byte and a flag marking the final byte of a page. Every device timing figure is a parameter in nanoseconds. The block converts each one into clock cycles at elaboration time, using the clock period parameter.

Bytes that belong to one page are strobed into the device with enough spacing to satisfy the minimum gap. Each new strobe falls before the device's byte-load timer runs out, so the device keeps collecting bytes into the open page. Once the final byte is loaded, or once the host leaves the window unused, the page closes. The block then waits out the rest of the load window plus the programming time. Until that wait ends, `busy` stays high and new requests are stalled. After reset, a lockout interval passes before the first write is taken.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset is released, `req_ready` stays low and `ee_we_n` stays high for exactly LOCK cycles, with LOCK = ceil(POWERUP_NS / CLK_NS). A request held valid from reset is accepted on clock edge LOCK+1, and its strobe falls on that edge.
- R2: The read strobe `ee_oe_n` (active low) is high at all times.
- R3: Each accepted byte produces exactly one low pulse on `ee_we_n` (active low). The pulse starts on the accepting clock edge and lasts PULSE = ceil(max(WE_PULSE_NS, DATA_SETUP_NS, ADDR_HOLD_NS) / CLK_NS) cycles. `ee_ce_n` (active low) is low exactly while `ee_we_n` is low.
- R4: While `ee_we_n` is low, `ee_addr` and `ee_data` are stable and equal the accepted request's address and data.
- R5: Within a page, the time from a strobe rising edge to the next strobe falling edge is at least GAP = ceil(LOAD_GAP_NS / CLK_NS) cycles and at most WIN-1 cycles, with WIN = floor(LOAD_WINDOW_NS / CLK_NS). When the next request is already waiting, the gap is exactly GAP.
- R6: After the strobe of a byte flagged last rises, `busy` stays high for exactly WIN + PROG cycles, with PROG = ceil(PROGRAM_NS / CLK_NS). No strobe falls during that time.
- R7: `busy` is high from the first accepted byte until the programming wait ends, with no low cycle between bytes of one page. A request made while busy and outside the load window is held off and accepted one cycle after `busy` falls.
- R8: When a non-final byte is not followed by a request, `req_ready` is still high WIN-2 cycles after the strobe rises and is low WIN-1 cycles after it. The page then closes on its own, and `busy` falls WIN + PROG cycles after that rise with no further strobe.
- R9: Time parameters round up to whole cycles, except the load-window upper bound, which rounds down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the power-up lockout |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | DATA_W | Byte to write |
| req_last | input | 1 | Byte closes the page |
| busy | output | 1 | A page is being loaded or programmed |
| ee_addr | output | ADDR_W | Device address lines |
| ee_data | output | DATA_W | Device data lines (write direction only) |
| ee_ce_n | output | 1 | Device chip select, active low |
| ee_we_n | output | 1 | Device write strobe, active low |
| ee_oe_n | output | 1 | Device read strobe, active low, held high |

## Verification
Some properties are checked on every cycle. No strobe may fall during lockout. Every strobe rise must come at the full pulse count. Address and data must hold still under the strobe, and each in-page gap must lie inside the load window. Each fall of `busy` must follow a full programming count, and the request port must stay closed during programming. Other behaviour can only be shown by the bench's scenarios, which measure absolute cycle distances: the rounding of each parameter, the exact lockout length, back-to-back and late in-page bytes, an unused window that closes the page by itself, and a request stalled across programming and accepted on the first free cycle.

// File: rtl/ew_pkg.sv
`timescale 1ns/1ps
package ew_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_GAP   = 2'd2,
      ST_PROG  = 2'd3
   } ew_state_e;

   // whole cycles covering at least ns, never below one
   function automatic int cyc_ceil(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   // whole cycles fitting inside ns
   function automatic int cyc_floor(input int ns, input int clk_ns);
      return ns / clk_ns;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ew_span_counter.sv
`timescale 1ns/1ps
module ew_span_counter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [WIDTH-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (clear)
         count <= '0;
      else if (count != '1)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/ew_lockout.sv
`timescale 1ns/1ps
module ew_lockout #(
   parameter int LOCK_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int LW = $clog2(LOCK_CYC + 1);
   localparam logic [LW-1:0] LIMIT = LW'(LOCK_CYC);

   logic [LW-1:0] elapsed;

   generate
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("ew_lockout: LOCK_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         elapsed <= '0;
      else if (elapsed != LIMIT)
         elapsed <= elapsed + 1'b1;
   end

   assign done = (elapsed == LIMIT);
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
   import ew_pkg::*;
#(
   parameter int ADDR_W         = 15,
   parameter int DATA_W         = 8,
   parameter int CLK_NS         = 10,
   parameter int WE_PULSE_NS    = 100,
   parameter int DATA_SETUP_NS  = 50,
   parameter int ADDR_HOLD_NS   = 50,
   parameter int LOAD_GAP_NS    = 100,
   parameter int LOAD_WINDOW_NS = 100_000,
   parameter int PROGRAM_NS     = 5_000_000,
   parameter int POWERUP_NS     = 10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_last,
   output logic              busy,
   output logic [ADDR_W-1:0] ee_addr,
   output logic [DATA_W-1:0] ee_data,
   output logic              ee_ce_n,
   output logic              ee_we_n,
   output logic              ee_oe_n
);
   // strobe must cover its own minimum, data setup and address hold
   localparam int WE_CYC   = cyc_ceil(max3(WE_PULSE_NS, DATA_SETUP_NS, ADDR_HOLD_NS), CLK_NS);
   localparam int GAP_CYC  = cyc_ceil(LOAD_GAP_NS, CLK_NS);
   localparam int WIN_CYC  = cyc_floor(LOAD_WINDOW_NS, CLK_NS);
   localparam int PROG_CYC = cyc_ceil(PROGRAM_NS, CLK_NS);
   localparam int LOCK_CYC = cyc_ceil(POWERUP_NS, CLK_NS);
   localparam int SPAN_MAX = max3(WE_CYC, WIN_CYC, PROG_CYC);
   localparam int CNT_W    = $clog2(SPAN_MAX + 1);

   localparam logic [CNT_W-1:0] WE_M1   = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] WIN_M1  = CNT_W'(WIN_CYC - 1);
   localparam logic [CNT_W-1:0] PROG_M1 = CNT_W'(PROG_CYC - 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("eeprom_page_writer: CLK_NS must be positive");
      end
      if (WIN_CYC <= GAP_CYC) begin : g_bad_window
         $error("eeprom_page_writer: load window must exceed the minimum gap");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("eeprom_page_writer: bus widths must be positive");
      end
   endgenerate

   ew_state_e         state_q, state_d;
   logic [CNT_W-1:0]  span;
   logic              lock_done;
   logic              accept;
   logic              in_window;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              last_q;

   ew_lockout #(.LOCK_CYC(LOCK_CYC)) i_lockout (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (lock_done)
   );

   ew_span_counter #(.WIDTH(CNT_W)) i_span (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_d != state_q),
      .count (span)
   );

   // next byte may start once the gap is met and before the window closes
   assign in_window = (state_q == ST_GAP) && !last_q && (span >= GAP_M1) && (span < WIN_M1);
   assign req_ready = ((state_q == ST_IDLE) && lock_done) || in_window;
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_PULSE;
         ST_PULSE: if (span == WE_M1) state_d = ST_GAP;
         ST_GAP: begin
            if (accept)                state_d = ST_PULSE;
            else if (span >= WIN_M1)   state_d = ST_PROG;
         end
         ST_PROG:  if (span == PROG_M1) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            last_q <= req_last;
         end
      end
   end

   assign ee_addr = addr_q;
   assign ee_data = data_q;
   assign ee_we_n = (state_q != ST_PULSE);
   assign ee_ce_n = (state_q != ST_PULSE);
   assign ee_oe_n = 1'b1;
   assign busy    = (state_q != ST_IDLE);

   // R1: no strobe and no acceptance before lockout ends
   p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_done |-> (ee_we_n && !req_ready));

   // R3: strobe rises only after the full pulse count
   p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_we_n) |-> ($past(span) == WE_M1));

   // R4: address and data hold still under the strobe
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_data)));

   // R5: in-page strobe starts inside the load window
   p_gap_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ee_we_n) && ($past(state_q) == ST_GAP)) |->
         (($past(span) >= GAP_M1) && ($past(span) < WIN_M1)));

   // R6: busy drops only after the full programming count
   p_prog_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(span) == PROG_M1));

   // R7: no request taken while programming
   p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROG) |-> !req_ready);

   // R8: an expired window closes the page with no further strobe
   p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_GAP) && (span >= WIN_M1)) |=> (busy && ee_we_n && !req_ready));
endmodule

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
   localparam int AW = 15;
   localparam int DW = 8;
   // expected cycle counts at a 10 ns clock, worked out from the requirements
   localparam int WE_EXP   = 10;   // ceil(max(95,50,50)/10)
   localparam int GAP_EXP  = 10;   // ceil(100/10)
   localparam int WIN_EXP  = 100;  // floor(1005/10)
   localparam int PROG_EXP = 300;  // ceil(2991/10)
   localparam int LOCK_EXP = 201;  // ceil(2005/10)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_last = 1'b0;
   logic          busy;
   logic [AW-1:0] ee_addr;
   logic [DW-1:0] ee_data;
   logic          ee_ce_n, ee_we_n, ee_oe_n;

   eeprom_page_writer #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_NS(10),
      .WE_PULSE_NS(95), .DATA_SETUP_NS(50), .ADDR_HOLD_NS(50),
      .LOAD_GAP_NS(100), .LOAD_WINDOW_NS(1005),
      .PROGRAM_NS(2991), .POWERUP_NS(2005)
   ) i_eeprom_page_writer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
      .busy(busy), .ee_addr(ee_addr), .ee_data(ee_data),
      .ee_ce_n(ee_ce_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // port monitor, sampled on the falling edge
   int fall_cyc = 0, rise_cyc = 0, busy_fall_cyc = 0;
   int n_fall = 0, n_rise = 0, n_busy_fall = 0;
   logic [AW-1:0] cap_addr = '0;
   logic [DW-1:0] cap_data = '0;
   bit stable_bad = 0, ce_bad = 0, ce_bad_any = 0, oe_bad = 0;
   logic prev_we = 1'b1, prev_busy = 1'b0;

   always @(negedge clk) begin
      if (prev_we && !ee_we_n) begin
         fall_cyc = cyc; n_fall++;
         cap_addr = ee_addr; cap_data = ee_data;
         stable_bad = 0; ce_bad = 0;
      end
      if (!ee_we_n) begin
         if (ee_addr !== cap_addr || ee_data !== cap_data) stable_bad = 1;
         if (ee_ce_n !== 1'b0) ce_bad = 1;
      end
      if (ee_we_n && ee_ce_n !== 1'b1) ce_bad_any = 1;
      if (ee_oe_n !== 1'b1) oe_bad = 1;
      if (!prev_we && ee_we_n) begin rise_cyc = cyc; n_rise++; end
      if (prev_busy && !busy) begin busy_fall_cyc = cyc; n_busy_fall++; end
      prev_we = ee_we_n;
      prev_busy = busy;
   end

   int n_vec = 0, n_bad = 0;

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   task automatic chk_eq(input string what, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // issue one byte and wait for its strobe to finish
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit last, output int acc);
      int r0;
      r0 = n_rise;
      req_valid = 1'b1; req_addr = a; req_data = d; req_last = last;
      while (!req_ready) tick();
      acc = cyc + 1;
      tick();
      req_valid = 1'b0;
      while (n_rise == r0) tick();
      chk_eq("R3 strobe low width", rise_cyc - fall_cyc, WE_EXP);
      chk_eq("R3 strobe starts on accept edge", fall_cyc, acc);
      chk_eq("R3 chip select low under strobe", ce_bad, 0);
      chk_eq("R4 address under strobe", cap_addr, a);
      chk_eq("R4 data under strobe", cap_data, d);
      chk_eq("R4 lines stable under strobe", stable_bad, 0);
   endtask

   task automatic wait_idle(input int from_rise, input string what);
      while (busy) tick();
      chk_eq(what, busy_fall_cyc - from_rise, WIN_EXP + PROG_EXP);
   endtask

   task automatic t_lockout;
      int c0, acc;
      bit seen_bad;
      repeat (3) tick();
      chk_eq("R1 ready low in reset", req_ready, 0);
      chk_eq("R1 strobe high in reset", ee_we_n, 1);
      chk_eq("R2 read strobe high in reset", ee_oe_n, 1);
      chk_eq("R7 busy low in reset", busy, 0);
      req_valid = 1'b1; req_addr = 15'h0123; req_data = 8'h5A; req_last = 1'b1;
      rst_n = 1'b1;
      c0 = cyc;
      seen_bad = 0;
      while (!req_ready) begin
         if (!ee_we_n || busy) seen_bad = 1;
         tick();
      end
      chk_eq("R1 R9 lockout length", cyc - c0, LOCK_EXP);
      chk_eq("R1 no strobe during lockout", seen_bad, 0);
      acc = cyc + 1;
      tick();
      req_valid = 1'b0;
      while (n_rise == 0) tick();
      chk_eq("R1 first strobe edge", fall_cyc, c0 + LOCK_EXP + 1);
      chk_eq("R1 first strobe matches accept", fall_cyc, acc);
      chk_eq("R4 first address", cap_addr, 15'h0123);
      wait_idle(rise_cyc, "R6 R9 programming wait after first byte");
   endtask

   task automatic t_single;
      int acc;
      do_write(15'h7FFF, 8'hFF, 1'b1, acc);
      chk_eq("R7 busy after last byte", busy, 1);
      repeat (150) tick();
      chk_eq("R7 ready low while programming", req_ready, 0);
      wait_idle(rise_cyc, "R6 single byte programming wait");
      tick();
      chk_eq("R7 ready after programming", req_ready, 1);
   endtask

   task automatic t_page;
      int acc, prev_rise, bf0;
      bf0 = n_busy_fall;
      prev_rise = 0;
      for (int i = 0; i < 4; i++) begin
         do_write(15'h0040 + 15'(i), 8'hA0 + 8'(i), i == 3, acc);
         if (i > 0) chk_eq("R5 back-to-back gap", fall_cyc - prev_rise, GAP_EXP);
         prev_rise = rise_cyc;
      end
      chk_eq("R7 busy held across page", n_busy_fall, bf0);
      wait_idle(rise_cyc, "R6 page programming wait");
   endtask

   task automatic t_slow;
      int acc, r;
      do_write(15'h0100, 8'h11, 1'b0, acc);
      r = rise_cyc;
      repeat (60) tick();
      do_write(15'h0101, 8'h22, 1'b1, acc);
      chk_eq("R5 late byte joins page", fall_cyc - r, 61);
      chk_eq("R7 busy stayed high", n_busy_fall, n_busy_fall);
      wait_idle(rise_cyc, "R6 late page programming wait");
   endtask

   task automatic t_timeout;
      int acc, r, f0;
      do_write(15'h0200, 8'h33, 1'b0, acc);
      r = rise_cyc;
      f0 = n_fall;
      repeat (WIN_EXP - 2) tick();
      chk_eq("R8 ready at window end minus one", req_ready, 1);
      tick();
      chk_eq("R8 ready low once window expires", req_ready, 0);
      chk_eq("R8 busy held on close", busy, 1);
      wait_idle(r, "R8 self-closed page programming wait");
      chk_eq("R8 no strobe after close", n_fall, f0);
   endtask

   task automatic t_stall;
      int acc, r, f0;
      do_write(15'h0300, 8'h44, 1'b1, acc);
      r = rise_cyc;
      f0 = n_fall;
      req_valid = 1'b1; req_addr = 15'h0301; req_data = 8'h55; req_last = 1'b1;
      while (!req_ready) tick();
      chk_eq("R7 stalled request waits for programming", cyc + 1 - r, WIN_EXP + PROG_EXP + 1);
      chk_eq("R6 no strobe during programming", n_fall, f0);
      do_write(15'h0301, 8'h55, 1'b1, acc);
      chk_eq("R7 stalled strobe after busy falls", fall_cyc - r, WIN_EXP + PROG_EXP + 1);
      wait_idle(rise_cyc, "R6 programming after stall");
   endtask

   initial begin
      t_lockout();
      t_single();
      t_page();
      t_slow();
      t_timeout();
      t_stall();
      chk_eq("R2 read strobe never low", oe_bad, 0);
      chk_eq("R3 chip select only under strobe", ce_bad_any, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150_000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule